// File: doc/BRIEF.md
# Vector Length Resolution Unit

This block holds the 64-bit control register through which software asks for a vector length. It turns that request into the effective vector length used by the rest of a processor. The request is a 4-bit length field: the requested length is (field + 1) × 128 bits. The block resolves the request in a fixed order. First, a limit from a more privileged level applies: when that level is present and the request is longer than its effective length, the limit's length is used directly. Otherwise, the request is rounded down to the longest length the implementation supports.

The supported set is given as a mask with one bit per power-of-two length, from 128 bits up to 2048 bits. Mask bits above the build-time maximum `MAX_LOG2` are dropped. The 128-bit length is always treated as supported. When the streaming flag is set, the output follows a separately resolved streaming length instead. The effective length leaves the block in two forms: a 3-bit log2 code, where 0 means 128 bits and 4 means 2048 bits, and a 12-bit count of bits.

A direct read of the register always returns the stored field as written. It never returns the resolved value. A write changes the effective length from the clock edge that stores it, with no extra delay.

Top module: `vlen_resolve`

## Requirements
- R1: After reset the stored length field is 0, `rd_data` reads 0, and with streaming off the effective length is code 0 (128 bits).
- R2: A write stores `wr_data[3:0]` as the length field. `rd_data[3:0]` returns that field, and `rd_data[63:4]` always reads zero, whatever value was written there. A cycle with `wr_en` low leaves the field unchanged.
- R3: The effective length reflects a write in the cycle after the clock edge that stores it, with no further latency.
- R4: When `hp_present` is 1 and (field + 1) × 128 is greater than 128 << `hp_code`, the non-streaming effective code equals `hp_code`, even if the mask lacks that length.
- R5: Otherwise, the non-streaming effective code is the largest code c with mask bit c set and 128 << c ≤ (field + 1) × 128.
- R6: Mask bit c stands for length 128 << c (c = 0..4). Bit 0 counts as set even when it is driven 0, and bits above `MAX_LOG2` count as clear.
- R7: When `stream_en` is 1, the effective code equals `stream_code`, whatever the field, the limit and the mask are.
- R8: `eff_bits` equals 128 << `eff_code` and is never above 2048.
- R9: A `hp_code` or `stream_code` value above 4 is treated as 4.
- R10: `rd_data` is never altered by clamping, masking or streaming; it always shows the stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write value |
| rd_data | output | 64 | Register readback (stored field, zero elsewhere) |
| hp_present | input | 1 | The more privileged level exists |
| hp_code | input | 3 | Effective length code of the more privileged level |
| sup_mask | input | 5 | Supported-length mask, bit c = 128 << c bits |
| stream_en | input | 1 | Streaming mode active |
| stream_code | input | 3 | Effective streaming length code |
| eff_code | output | 3 | Effective length, log2 code (0 = 128 bits) |
| eff_bits | output | 12 | Effective length in bits |

## Verification
On every cycle, the assertions check the following:
- the upper readback bits read zero, and the field is held when there is no write;
- a write lands in the next cycle;
- the rounded code never exceeds the request code;
- the resolved code always hits a supported mask bit;
- a clamp never exceeds the limit;
- streaming passes its code through.

Only the bench's scenarios can show that the chosen length is the longest legal one. The bench covers this with every field value against an independent reference, under several masks and limits. It also covers where the limit sits relative to the request (equal, below, above), saturation of out-of-range codes, and reset in the middle of a run.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
   localparam int REG_W     = 64;
   localparam int LEN_W     = 4;
   localparam int CODE_W    = 3;
   localparam int NUM_CODES = 5;
   localparam int BITS_W    = 12;
   localparam int BASE_BITS = 128;

   function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] c);
      if (c > CODE_W'(NUM_CODES - 1)) return CODE_W'(NUM_CODES - 1);
      return c;
   endfunction
endpackage

// File: rtl/vlr_len_reg.sv
module vlr_len_reg #(
   parameter int REG_W = 64,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [LEN_W-1:0] len_q,
   output logic [REG_W-1:0] rd_data
);
   localparam int PAD_W = REG_W - LEN_W;

   logic unused_hi;
   assign unused_hi = ^wr_data[REG_W-1:LEN_W];

   always_ff @(posedge clk) begin
      if (rst)        len_q <= '0;
      else if (wr_en) len_q <= wr_data[LEN_W-1:0];
   end

   assign rd_data = {{PAD_W{1'b0}}, len_q};
endmodule

// File: rtl/vlr_clamp.sv
module vlr_clamp #(
   parameter int LEN_W     = 4,
   parameter int CODE_W    = 3,
   parameter int NUM_CODES = 5
) (
   input  logic [LEN_W-1:0]  len,
   input  logic              hp_present,
   input  logic [CODE_W-1:0] hp_code,
   output logic [CODE_W-1:0] req_code,
   output logic              use_hp
);
   localparam int U_W = LEN_W + 1;

   logic [U_W-1:0] units;
   logic [U_W-1:0] hp_units;

   assign units    = U_W'(len) + U_W'(1);
   assign hp_units = U_W'(1) << hp_code;
   assign use_hp   = hp_present && (units > hp_units);

   always_comb begin
      req_code = '0;
      for (int i = 0; i < U_W; i++)
         if (units[i]) req_code = CODE_W'(i);
      if (req_code > CODE_W'(NUM_CODES - 1)) req_code = CODE_W'(NUM_CODES - 1);
   end
endmodule

// File: rtl/vlr_round_down.sv
module vlr_round_down #(
   parameter int NUM_CODES = 5,
   parameter int MAX_LOG2  = 4,
   parameter int CODE_W    = 3
) (
   input  logic [NUM_CODES-1:0] mask_in,
   input  logic [CODE_W-1:0]    limit,
   output logic [NUM_CODES-1:0] mask_eff,
   output logic [CODE_W-1:0]    out_code
);
   for (genvar g = 0; g < NUM_CODES; g++) begin : g_mask
      if (g == 0) begin : g_base
         assign mask_eff[g] = 1'b1;
      end else if (g <= MAX_LOG2) begin : g_impl
         assign mask_eff[g] = mask_in[g];
      end else begin : g_absent
         assign mask_eff[g] = 1'b0;
      end
   end

   logic unused_mask;
   assign unused_mask = mask_in[0];

   always_comb begin
      out_code = '0;
      for (int i = 0; i < NUM_CODES; i++)
         if (mask_eff[i] && (CODE_W'(i) <= limit)) out_code = CODE_W'(i);
   end
endmodule

// File: rtl/vlen_resolve.sv
module vlen_resolve
   import vlr_pkg::*;
#(
   parameter int MAX_LOG2 = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [REG_W-1:0]     wr_data,
   output logic [REG_W-1:0]     rd_data,
   input  logic                 hp_present,
   input  logic [CODE_W-1:0]    hp_code,
   input  logic [NUM_CODES-1:0] sup_mask,
   input  logic                 stream_en,
   input  logic [CODE_W-1:0]    stream_code,
   output logic [CODE_W-1:0]    eff_code,
   output logic [BITS_W-1:0]    eff_bits
);
   if (MAX_LOG2 < 0 || MAX_LOG2 > NUM_CODES - 1) begin : g_bad_max
      $error("MAX_LOG2 out of range");
   end
   if ((BASE_BITS << (NUM_CODES - 1)) >= (1 << BITS_W)) begin : g_bad_bits
      $error("BITS_W too narrow");
   end

   logic [LEN_W-1:0]     len_q;
   logic [CODE_W-1:0]    hp_sat, st_sat, req_code, rnd_code, ns_code;
   logic [NUM_CODES-1:0] mask_eff;
   logic                 use_hp;

   assign hp_sat = sat_code(hp_code);
   assign st_sat = sat_code(stream_code);

   vlr_len_reg #(.REG_W(REG_W), .LEN_W(LEN_W)) u_reg (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .len_q(len_q), .rd_data(rd_data)
   );

   vlr_clamp #(.LEN_W(LEN_W), .CODE_W(CODE_W), .NUM_CODES(NUM_CODES)) u_clamp (
      .len(len_q), .hp_present(hp_present), .hp_code(hp_sat),
      .req_code(req_code), .use_hp(use_hp)
   );

   vlr_round_down #(.NUM_CODES(NUM_CODES), .MAX_LOG2(MAX_LOG2), .CODE_W(CODE_W)) u_round (
      .mask_in(sup_mask), .limit(req_code), .mask_eff(mask_eff), .out_code(rnd_code)
   );

   assign ns_code  = use_hp ? hp_sat : rnd_code;
   assign eff_code = stream_en ? st_sat : ns_code;
   assign eff_bits = BITS_W'(BASE_BITS) << eff_code;

   // R2
   rd_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
      rd_data[REG_W-1:LEN_W] == '0);
   // R2
   hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(rd_data));
   // R3
   write_lands_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> rd_data[LEN_W-1:0] == $past(wr_data[LEN_W-1:0]));
   // R5
   round_not_above_chk: assert property (@(posedge clk) disable iff (rst)
      rnd_code <= req_code);
   // R6
   round_supported_chk: assert property (@(posedge clk) disable iff (rst)
      mask_eff[rnd_code] == 1'b1);
   // R4
   clamp_within_limit_chk: assert property (@(posedge clk) disable iff (rst)
      (hp_present && !stream_en) |-> eff_code <= hp_sat);
   // R7
   stream_pass_chk: assert property (@(posedge clk) disable iff (rst)
      stream_en |-> eff_code == st_sat);
   // R8
   bits_range_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(eff_bits) == 1 && eff_bits <= BITS_W'(2048));
endmodule

// File: tb/vlen_resolve_test.sv
module vlen_resolve_test;
   logic        clk = 0;
   logic        rst = 1;
   logic        wr_en = 0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_data;
   logic        hp_present = 0;
   logic [2:0]  hp_code = '0;
   logic [4:0]  sup_mask = 5'h1F;
   logic        stream_en = 0;
   logic [2:0]  stream_code = '0;
   logic [2:0]  eff_code;
   logic [11:0] eff_bits;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   vlen_resolve uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .hp_present(hp_present), .hp_code(hp_code), .sup_mask(sup_mask),
      .stream_en(stream_en), .stream_code(stream_code),
      .eff_code(eff_code), .eff_bits(eff_bits)
   );

   // fields: len[19:16] hp[15] hpc[14:12] mask[11:7] st[6] stc[5:3] exp[2:0]
   localparam int NV = 15;
   localparam logic [19:0] VEC [NV] = '{
      {4'd0,  1'b0, 3'd0, 5'h1F, 1'b0, 3'd0, 3'd0},
      {4'd1,  1'b0, 3'd0, 5'h1F, 1'b0, 3'd0, 3'd1},
      {4'd2,  1'b0, 3'd0, 5'h1F, 1'b0, 3'd0, 3'd1},
      {4'd15, 1'b0, 3'd0, 5'h1F, 1'b0, 3'd0, 3'd4},
      {4'd15, 1'b0, 3'd0, 5'h07, 1'b0, 3'd0, 3'd2},
      {4'd15, 1'b0, 3'd0, 5'h0A, 1'b0, 3'd0, 3'd3},
      {4'd6,  1'b0, 3'd0, 5'h0A, 1'b0, 3'd0, 3'd1},
      {4'd15, 1'b1, 3'd2, 5'h1F, 1'b0, 3'd0, 3'd2},
      {4'd3,  1'b1, 3'd2, 5'h03, 1'b0, 3'd0, 3'd1},
      {4'd15, 1'b1, 3'd3, 5'h03, 1'b0, 3'd0, 3'd3},
      {4'd15, 1'b0, 3'd0, 5'h00, 1'b0, 3'd0, 3'd0},
      {4'd0,  1'b0, 3'd0, 5'h1F, 1'b1, 3'd3, 3'd3},
      {4'd9,  1'b1, 3'd1, 5'h00, 1'b1, 3'd7, 3'd4},
      {4'd15, 1'b1, 3'd6, 5'h1F, 1'b0, 3'd0, 3'd4},
      {4'd4,  1'b1, 3'd5, 5'h1F, 1'b0, 3'd0, 3'd2}
   };

   function automatic int ref_code(int len, bit hp, int hpc, logic [4:0] m);
      int req = (len + 1) * 128;
      int best = 0;
      if (hpc > 4) hpc = 4;
      if (hp && req > (128 << hpc)) return hpc;
      for (int i = 0; i < 5; i++)
         if ((i == 0 || m[i]) && (128 << i) <= req) best = i;
      return best;
   endfunction

   task automatic chk(string req, longint act, longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [63:0] v);
      @(negedge clk); wr_en = 1; wr_data = v;
      @(negedge clk); wr_en = 0; wr_data = ~v;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1 reset state
      chk("R1 rd_data", rd_data, 0);
      chk("R1 eff_code", eff_code, 0);
      chk("R1 eff_bits", eff_bits, 128);

      for (int k = 0; k < NV; k++) begin
         logic [19:0] v = VEC[k];
         @(negedge clk);
         hp_present = v[15]; hp_code = v[14:12]; sup_mask = v[11:7];
         stream_en = v[6]; stream_code = v[5:3];
         do_write({60'hA5A5_F00D_1234_567, v[19:16]});
         // R3 R4 R5 R6 R7 R9: effective code right after the write edge
         chk("R5/R4/R7/R9 vector eff_code", eff_code, v[2:0]);
         // R8
         chk("R8 vector eff_bits", eff_bits, 128 << v[2:0]);
         // R2 R10 readback unchanged by resolution
         chk("R2/R10 vector rd_data", rd_data, {60'h0, v[19:16]});
      end

      // R4 R5 full sweep against the reference under several settings
      stream_en = 0;
      for (int s = 0; s < 3; s++) begin
         hp_present = (s == 2);
         hp_code    = 3'd2;
         sup_mask   = (s == 0) ? 5'h1F : 5'h15;
         for (int l = 0; l < 16; l++) begin
            do_write(64'(l));
            chk("R4/R5 sweep eff_code", eff_code,
                ref_code(l, hp_present, int'(hp_code), sup_mask));
         end
      end

      // R2 no write: field held while wr_data changes
      do_write(64'hFFFF_FFFF_FFFF_FFF7);
      @(negedge clk); wr_data = 64'h3; @(negedge clk); @(negedge clk);
      chk("R2 hold without write", rd_data, 64'h7);

      // R1 reset in the middle of a run
      do_write(64'h9);
      rst = 1; @(negedge clk); rst = 0; @(negedge clk);
      chk("R1 mid-run reset rd_data", rd_data, 0);
      chk("R1 mid-run reset eff_code", eff_code, 0);

      finish_run();
   end
endmodule